// File: doc/BRIEF.md
# Rising-Edge Set/Clear Storage Cell

This block holds one bit, `q`, that is moved only by rising transitions on two control lines. A rising `s` makes `q` one and a rising `r` makes `q` zero. Steady levels on either line never touch the stored bit, so both lines may sit high together. When both are high, the line that rose most recently decides the value. The cell is a clocked model. Both lines are sampled on every clock edge. They are expected to arrive already synchronized and to change one at a time.

Inside, a two-bit register keeps the last sampled value of each line. From this the block finds the line that changed in the current sample and the direction it moved. A four-state controller holds the remaining history. Two states are plain cleared and set. Two more record that the last rise happened while the other line was already high, so the block knows what to do when that other line later falls. `q` is decoded from the state register. It follows the sampled edge one clock later.

A sample in which both lines changed breaks the one-change-at-a-time rule. The controller ignores such a sample and keeps its state.

Top module: `edge_sr_cell`

## Requirements
- R1: While `rst_n` is low, `q` is 0, the controller is in the cleared state and both stored previous samples are 0. As a result, a line that is already high when reset is released counts as a rising edge on the first clock after release.
- R2: From the cleared state with both lines low, raising `s` alone makes `q` 1 on the clock edge that samples the rise. Before that edge, `q` stays 0.
- R3: From the cleared state with both lines low, raising `r` alone leaves `q` at 0.
- R4: For as long as both inputs keep the same values from sample to sample, whatever those values are (including `s`=`r`=1), `q` does not change.
- R5: After `s` has set `q` to 1, dropping `s` keeps `q` at 1. A later rise of `r` clears `q` to 0.
- R6: With `r` held high and `q` at 0, a rise of `s` makes `q` 1.
- R7: With `s` held high and `q` at 1, a rise of `r` makes `q` 0.
- R8: After `r` has cleared `q` while `s` was high, `q` stays 0 through each of these changes: `r` falling, `r` rising again, `s` falling. Once both lines are low, a fresh rise of `s` sets `q` to 1.
- R9: After `s` has set `q` while `r` was high, `q` stays 1 through each of these changes: `s` falling, `r` falling. Once `s` is low, a rise of `r` clears `q`.
- R10: A sample in which both lines differ from their previous sample leaves `q` and the controller state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| s | input | 1 | Set request; acts on its rising transition |
| r | input | 1 | Clear request; acts on its rising transition |
| q | output | 1 | Stored bit |

## Verification
The hardest cases occur when both lines are high, because the value of `q` there depends on which line rose last. A design that decodes levels would either lock `q` at 11 or let the most recent fall undo the last rise. The bench therefore walks both held-high histories through every single-line fall and through re-rises. It also injects a simultaneous change of both lines: a cell that does not hold in that case would set or clear on a sample the protocol forbids. Other targeted cases are a line held high through reset release, which a cell that fails to clear its previous sample would miss, and the one-clock latency from sample to output.

// File: rtl/edge_sr_pkg.sv
package edge_sr_pkg;

  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_S    = 0;
  localparam int unsigned LINE_R    = 1;
  localparam int unsigned ST_W      = 2;

  // bit 0 of the code is the stored value; bit 1 marks "other line was high at last rise"
  typedef enum logic [ST_W-1:0] {
    ST_CLR   = 2'b00,
    ST_SET   = 2'b01,
    ST_RLAST = 2'b10,
    ST_SLAST = 2'b11
  } sr_state_e;

endpackage

// File: rtl/edge_sr_change_det.sv
module edge_sr_change_det #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] lvl,
  output logic [NCH-1:0] prev,
  output logic [NCH-1:0] rise,
  output logic [NCH-1:0] fall,
  output logic           one_change
);

  logic [NCH-1:0] chg;
  logic [NCH-1:0] chg_minus1;

  for (genvar g = 0; g < NCH; g++) begin : g_line
    logic prev_nxt;

    always_comb begin
      prev_nxt = lvl[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev[g] <= 1'b0;
      end else begin
        prev[g] <= prev_nxt;
      end
    end

    always_comb begin
      rise[g] = lvl[g] & ~prev[g];
      fall[g] = ~lvl[g] & prev[g];
      chg[g]  = lvl[g] ^ prev[g];
    end
  end

  always_comb begin
    chg_minus1 = chg - NCH'(1);
    one_change = (chg != '0) && ((chg & chg_minus1) == '0);
  end

  // R1
  prev_zero_in_reset_chk: assert property (@(posedge clk) !rst_n |-> (prev == '0));

endmodule

// File: rtl/edge_sr_next_state.sv
module edge_sr_next_state
  import edge_sr_pkg::*;
(
  input  sr_state_e            cur,
  input  logic                 s_lvl,
  input  logic                 r_lvl,
  input  logic [NUM_LINES-1:0] rise,
  output sr_state_e            nxt
);

  always_comb begin
    nxt = cur;
    if (rise[LINE_S]) begin
      nxt = r_lvl ? ST_SLAST : ST_SET;
    end else if (rise[LINE_R]) begin
      nxt = s_lvl ? ST_RLAST : ST_CLR;
    end else begin
      unique case (cur)
        ST_SLAST: nxt = (!s_lvl && r_lvl) ? ST_SLAST : ST_SET;
        ST_RLAST: nxt = (s_lvl && !r_lvl) ? ST_RLAST : ST_CLR;
        default:  nxt = cur;
      endcase
    end
  end

endmodule

// File: rtl/edge_sr_state_reg.sv
module edge_sr_state_reg
  import edge_sr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  sr_state_e nxt,
  output sr_state_e cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= ST_CLR;
    end else if (en) begin
      cur <= nxt;
    end
  end

endmodule

// File: rtl/edge_sr_cell.sv
module edge_sr_cell
  import edge_sr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  input  logic r,
  output logic q
);

  logic [NUM_LINES-1:0] lvl;
  logic [NUM_LINES-1:0] prev;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] fall;
  logic                 one_change;
  sr_state_e            st_cur;
  sr_state_e            st_nxt;

  always_comb begin
    lvl         = '0;
    lvl[LINE_S] = s;
    lvl[LINE_R] = r;
  end

  edge_sr_change_det #(
    .NCH (NUM_LINES)
  ) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl        (lvl),
    .prev       (prev),
    .rise       (rise),
    .fall       (fall),
    .one_change (one_change)
  );

  edge_sr_next_state u_nxt (
    .cur   (st_cur),
    .s_lvl (s),
    .r_lvl (r),
    .rise  (rise),
    .nxt   (st_nxt)
  );

  edge_sr_state_reg u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (one_change),
    .nxt   (st_nxt),
    .cur   (st_cur)
  );

  always_comb begin
    q = (st_cur == ST_SET) || (st_cur == ST_SLAST);
  end

  // R1
  q_low_in_reset_chk: assert property (@(posedge clk) !rst_n |-> (q == 1'b0));

  // R2 R6
  s_rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s && !prev[LINE_S] && (r == prev[LINE_R])) |=> q);

  // R3 R7
  r_rise_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r && !prev[LINE_R] && (s == prev[LINE_S])) |=> !q);

  // R4
  steady_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((s == prev[LINE_S]) && (r == prev[LINE_R])) |=> $stable(q));

  // R5 R8 R9
  fall_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall != '0) && !(s && !prev[LINE_S]) && !(r && !prev[LINE_R])) |=> $stable(q));

  // R10
  dual_change_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((s != prev[LINE_S]) && (r != prev[LINE_R])) |=> ($stable(q) && $stable(st_cur)));

endmodule

// File: tb/edge_sr_cell_bench.sv
module edge_sr_cell_bench;

  logic clk;
  logic rst_n;
  logic s;
  logic r;
  logic q;
  int   checks;
  int   failures;
  bit   done;

  edge_sr_cell u_edge_sr_cell (
    .clk   (clk),
    .rst_n (rst_n),
    .s     (s),
    .r     (r),
    .q     (q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic exp);
    checks++;
    if (q !== exp) begin
      failures++;
      $display("FAIL %s: q=%b expected=%b at %0t", tag, q, exp, $time);
    end
  endtask

  // inputs change just after a rising edge; q is read just after the next edge
  task automatic apply(input logic sv, input logic rv);
    s = sv;
    r = rv;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic sv, input logic rv);
    s     = sv;
    r     = rv;
    rst_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R1 reset value", 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b0);
    apply(1'b0, 1'b0);
    check("R1 idle after release", 1'b0);
    do_reset(1'b1, 1'b0);
    @(posedge clk);
    #1;
    check("R1 held s counts as rise after release", 1'b1);
  endtask

  task automatic t_set_from_idle;
    do_reset(1'b0, 1'b0);
    @(posedge clk);
    #1;
    s = 1'b1;
    #3;
    check("R2 q unchanged before sampling edge", 1'b0);
    @(posedge clk);
    #1;
    check("R2 s rise sets", 1'b1);
    for (int i = 0; i < 4; i++) apply(1'b1, 1'b0);
    check("R4 steady 10 holds", 1'b1);
  endtask

  task automatic t_clear_from_idle;
    do_reset(1'b0, 1'b0);
    apply(1'b0, 1'b1);
    check("R3 r rise keeps 0", 1'b0);
    for (int i = 0; i < 4; i++) apply(1'b0, 1'b1);
    check("R4 steady 01 holds", 1'b0);
  endtask

  task automatic t_fall_then_clear;
    do_reset(1'b0, 1'b0);
    apply(1'b1, 1'b0);
    check("R5 set", 1'b1);
    apply(1'b0, 1'b0);
    check("R5 s fall keeps 1", 1'b1);
    for (int i = 0; i < 3; i++) apply(1'b0, 1'b0);
    check("R4 steady 00 holds 1", 1'b1);
    apply(1'b0, 1'b1);
    check("R5 r rise clears", 1'b0);
  endtask

  task automatic t_s_over_r;
    do_reset(1'b0, 1'b0);
    apply(1'b0, 1'b1);
    apply(1'b1, 1'b1);
    check("R6 s rise with r high sets", 1'b1);
    for (int i = 0; i < 5; i++) apply(1'b1, 1'b1);
    check("R4 steady 11 holds 1", 1'b1);
  endtask

  task automatic t_r_over_s;
    do_reset(1'b0, 1'b0);
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b1);
    check("R7 r rise with s high clears", 1'b0);
    for (int i = 0; i < 5; i++) apply(1'b1, 1'b1);
    check("R4 steady 11 holds 0", 1'b0);
  endtask

  task automatic t_rlast_paths;
    do_reset(1'b0, 1'b0);
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b1);
    apply(1'b1, 1'b0);
    check("R8 r fall keeps 0", 1'b0);
    apply(1'b1, 1'b1);
    check("R8 r re-rise keeps 0", 1'b0);
    apply(1'b1, 1'b0);
    apply(1'b0, 1'b0);
    check("R8 s fall to 00 keeps 0", 1'b0);
    apply(1'b1, 1'b0);
    check("R8 fresh s rise sets", 1'b1);
    do_reset(1'b0, 1'b0);
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b1);
    apply(1'b0, 1'b1);
    check("R8 s fall to 01 keeps 0", 1'b0);
  endtask

  task automatic t_slast_paths;
    do_reset(1'b0, 1'b0);
    apply(1'b0, 1'b1);
    apply(1'b1, 1'b1);
    apply(1'b1, 1'b0);
    check("R9 r fall to 10 keeps 1", 1'b1);
    do_reset(1'b0, 1'b0);
    apply(1'b0, 1'b1);
    apply(1'b1, 1'b1);
    apply(1'b0, 1'b1);
    check("R9 s fall to 01 keeps 1", 1'b1);
    apply(1'b0, 1'b0);
    check("R9 r fall to 00 keeps 1", 1'b1);
    apply(1'b0, 1'b1);
    check("R9 r rise clears", 1'b0);
  endtask

  task automatic t_dual_change;
    do_reset(1'b0, 1'b0);
    $display("note: protocol violation injected (both lines change in one sample)");
    apply(1'b1, 1'b1);
    check("R10 both rise from cleared keeps 0", 1'b0);
    apply(1'b1, 1'b0);
    check("R10 r fall afterwards keeps 0", 1'b0);
    do_reset(1'b0, 1'b0);
    apply(1'b1, 1'b0);
    apply(1'b0, 1'b0);
    $display("note: protocol violation injected (both lines change in one sample)");
    apply(1'b1, 1'b1);
    check("R10 both rise from set keeps 1", 1'b1);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    s        = 1'b0;
    r        = 1'b0;
    rst_n    = 1'b0;
    t_reset();
    t_set_from_idle();
    t_clear_from_idle();
    t_fall_then_clear();
    t_s_over_r();
    t_r_over_s();
    t_rlast_paths();
    t_slast_paths();
    t_dual_change();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule